// File: doc/BRIEF.md
# Time-Aware Gate Schedule Sequencer

This block steps through a repeating gate-control list for eight egress priorities. Each list entry is a packed 22-bit word. It names a set of priorities that may transmit and how many wire clocks that set stays in force. A periodic cycle-start pulse from an external time base restarts the list at its first entry. While the list runs, the block drives the current 8-bit gate-open mask to the transmit scheduler.

The entries live in a 128-word fetch RAM, which can be used in one of two ways:

- **Split mode.** The RAM is two 64-entry banks. One bank drives the gates while software fills the other. A commit strobe arms a swap, and the swap takes effect only at the next cycle start, so a running cycle is never torn.
- **Single mode.** The RAM is one 128-entry list, which allows longer schedules. An interval longer than one entry can hold is spread over several consecutive entries.

Top module: `gate_sched_seq`

## Requirements
- R1: After reset, `gateMask` is 8'hFF, and it stays 8'hFF until the first `cycleStart` pulse sampled while `enable` is high.
- R2: Each entry word has the count in bits [21:8] and the allow mask in bits [7:0]. A loaded entry with count N drives its mask on `gateMask` for exactly N clocks. The first of those clocks is the clock right after the edge that sampled `cycleStart`.
- R3: Entries are taken in ascending address order, back to back, with no idle clock between them.
- R4: An entry with a zero count ends the cycle. The mask already on `gateMask` is held until the next `cycleStart`.
- R5: When the last entry of the bank has run out (entry 63 in split mode, entry 127 in single mode), its mask is held until the next `cycleStart`.
- R6: A `cycleStart` pulse while enabled restarts the list at entry 0, even in the middle of an entry.
- R7: In split mode, `commit` only arms a bank swap, and the running list is not disturbed. The swap happens at the next `cycleStart`. Without a new commit, later cycles repeat the same bank.
- R8: In split mode, `wrAddr[6]` selects the bank and `wrAddr[5:0]` selects the entry. A write to the bank currently driving the gates is dropped. A write to the other bank is stored.
- R9: In single mode, the RAM is one list of 128 entries that runs across address 63 into 64. Every address is writable.
- R10: While `enable` is low, `gateMask` is 8'hFF from the next clock and `cycleStart` has no effect. After `enable` returns high, the mask stays 8'hFF until a `cycleStart` pulse.
- R11: If entry 0 has a zero count, `gateMask` keeps the value it had before the `cycleStart` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Wire-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Sequencer run enable; low forces all gates open |
| splitMode | input | 1 | 1: two 64-entry banks, 0: one 128-entry list |
| cycleStart | input | 1 | One-clock pulse marking the start of a schedule cycle |
| wrEn | input | 1 | Fetch RAM write strobe |
| wrAddr | input | 7 | Fetch RAM write address (bit 6 is the bank in split mode) |
| wrData | input | 22 | Entry word: count [21:8], allow mask [7:0] |
| commit | input | 1 | Marks the inactive bank as ready for the next cycle start |
| gateMask | output | 8 | Current gate-open mask, one bit per priority |

## Verification
The assertions assume four things about the inputs:

- `splitMode` changes only while `enable` is low.
- `cycleStart` is a single-clock pulse.
- `commit` never coincides with a `cycleStart` that performs a swap.
- Every list that is started ends in a zero-count entry or at the end of its bank.

The stimulus holds to all four. It switches mode only with the sequencer disabled, and it drives every control pulse for exactly one clock through dedicated tasks. It issues commits several clocks away from any cycle start. It programs each list with an explicit terminator or fills the whole bank.

// File: rtl/gsq_pkg.sv
package gsq_pkg;

  localparam int GSQ_CNT_W  = 14;
  localparam int GSQ_MASK_W = 8;
  localparam int GSQ_BANK_D = 64;

  typedef struct packed {
    logic loadEntry;  // take the addressed entry into the mask and count registers
    logic decRemain;  // count down the current entry
    logic forceOpen;  // drive all gates open
    logic wrAllow;    // host write may reach the RAM
  } gsqStrobes_t;

endpackage

// File: rtl/gsq_fetch_ram.sv
module gsq_fetch_ram #(
  parameter int WORD_W = 22,
  parameter int DEPTH  = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData
);

  logic [WORD_W-1:0] mem [DEPTH];

  // Each word is a plain register with its own write select, so the read
  // path is a combinational mux and a freshly loaded entry costs no cycle.
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (wrEn && (wrAddr == ADDR_W'(g))) begin
        mem[g] <= wrData;
      end
    end
  end

  assign rdData = mem[rdAddr];

endmodule

// File: rtl/gsq_datapath.sv
module gsq_datapath
  import gsq_pkg::*;
#(
  parameter int CNT_W      = GSQ_CNT_W,
  parameter int MASK_W     = GSQ_MASK_W,
  parameter int BANK_DEPTH = GSQ_BANK_D,
  localparam int TOTAL  = 2 * BANK_DEPTH,
  localparam int ADDR_W = $clog2(TOTAL),
  localparam int WORD_W = CNT_W + MASK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gsqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  output logic [CNT_W-1:0]  entryCount,
  output logic              remainZero,
  output logic [MASK_W-1:0] gateMask
);

  logic [WORD_W-1:0] rdWord;
  logic [MASK_W-1:0] entryMask;
  logic [CNT_W-1:0]  remain;
  logic [MASK_W-1:0] maskReg;

  gsq_fetch_ram #(
    .WORD_W(WORD_W),
    .DEPTH (TOTAL)
  ) ram_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wrEn  (wrEn && strobes.wrAllow),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .rdData(rdWord)
  );

  assign entryCount = rdWord[WORD_W-1:MASK_W];
  assign entryMask  = rdWord[MASK_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskReg <= '1;
    end else if (strobes.forceOpen) begin
      maskReg <= '1;
    end else if (strobes.loadEntry) begin
      maskReg <= entryMask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (strobes.loadEntry) begin
      remain <= entryCount - CNT_W'(1);
    end else if (strobes.decRemain) begin
      remain <= remain - CNT_W'(1);
    end
  end

  assign remainZero = (remain == '0);
  assign gateMask   = maskReg;

endmodule

// File: rtl/gsq_control.sv
module gsq_control
  import gsq_pkg::*;
#(
  parameter int CNT_W      = GSQ_CNT_W,
  parameter int BANK_DEPTH = GSQ_BANK_D,
  localparam int TOTAL  = 2 * BANK_DEPTH,
  localparam int ADDR_W = $clog2(TOTAL),
  localparam int IDX_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              splitMode,
  input  logic              cycleStart,
  input  logic              commit,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  entryCount,
  input  logic              remainZero,
  output gsqStrobes_t       strobes,
  output logic [ADDR_W-1:0] rdAddr
);

  logic             running;
  logic             holding;
  logic             activeBank;
  logic             pendingReady;
  logic [IDX_W-1:0] ptr;

  logic             startNow;
  logic             swapNow;
  logic             bankSel;
  logic             countZero;
  logic [IDX_W-1:0] rdIdx;
  logic [IDX_W-1:0] bankEnd;

  assign startNow  = enable && cycleStart;
  assign swapNow   = startNow && splitMode && pendingReady;
  assign bankSel   = swapNow ? ~activeBank : activeBank;
  assign countZero = (entryCount == '0);
  assign rdIdx     = startNow ? '0 : ptr;
  assign bankEnd   = splitMode ? IDX_W'(BANK_DEPTH) : IDX_W'(TOTAL);

  // Split mode: the top address bit is the bank. Single mode: flat index.
  assign rdAddr = splitMode ? {bankSel, rdIdx[ADDR_W-2:0]} : rdIdx[ADDR_W-1:0];

  always_comb begin
    strobes           = '0;
    strobes.forceOpen = !enable;
    strobes.wrAllow   = !splitMode || (wrAddr[ADDR_W-1] != activeBank);
    if (startNow) begin
      strobes.loadEntry = !countZero;
    end else if (enable && running && !holding) begin
      if (!remainZero) begin
        strobes.decRemain = 1'b1;
      end else if ((ptr != bankEnd) && !countZero) begin
        strobes.loadEntry = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      holding <= 1'b0;
      ptr     <= '0;
    end else if (!enable) begin
      running <= 1'b0;
      holding <= 1'b0;
      ptr     <= '0;
    end else if (startNow) begin
      running <= 1'b1;
      holding <= countZero;
      ptr     <= IDX_W'(1);
    end else if (running && !holding && remainZero) begin
      if (strobes.loadEntry) begin
        ptr <= ptr + IDX_W'(1);
      end else begin
        holding <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeBank <= 1'b0;
    end else if (swapNow) begin
      activeBank <= ~activeBank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendingReady <= 1'b0;
    end else if (commit && splitMode) begin
      pendingReady <= 1'b1;
    end else if (swapNow) begin
      pendingReady <= 1'b0;
    end
  end

endmodule

// File: rtl/gate_sched_seq.sv
module gate_sched_seq
  import gsq_pkg::*;
#(
  parameter int CNT_W      = GSQ_CNT_W,
  parameter int MASK_W     = GSQ_MASK_W,
  parameter int BANK_DEPTH = GSQ_BANK_D,
  localparam int TOTAL  = 2 * BANK_DEPTH,
  localparam int ADDR_W = $clog2(TOTAL),
  localparam int WORD_W = CNT_W + MASK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              splitMode,
  input  logic              cycleStart,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              commit,
  output logic [MASK_W-1:0] gateMask
);

  gsqStrobes_t       strobes;
  logic [ADDR_W-1:0] rdAddr;
  logic [CNT_W-1:0]  entryCount;
  logic              remainZero;

  gsq_control #(
    .CNT_W     (CNT_W),
    .BANK_DEPTH(BANK_DEPTH)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .splitMode (splitMode),
    .cycleStart(cycleStart),
    .commit    (commit),
    .wrAddr    (wrAddr),
    .entryCount(entryCount),
    .remainZero(remainZero),
    .strobes   (strobes),
    .rdAddr    (rdAddr)
  );

  gsq_datapath #(
    .CNT_W     (CNT_W),
    .MASK_W    (MASK_W),
    .BANK_DEPTH(BANK_DEPTH)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .rdAddr    (rdAddr),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .entryCount(entryCount),
    .remainZero(remainZero),
    .gateMask  (gateMask)
  );

endmodule

// File: rtl/gsq_checker.sv
module gsq_checker #(
  parameter int CNT_W  = 14,
  parameter int MASK_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              cycleStart,
  input logic [MASK_W-1:0] gateMask,
  input logic              loadEntry,
  input logic              holding,
  input logic              activeBank,
  input logic              pendingReady,
  input logic [CNT_W-1:0]  entryCount,
  input logic              remainZero
);

  logic seenStart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seenStart <= 1'b0;
    end else if (!enable) begin
      seenStart <= 1'b0;
    end else if (cycleStart) begin
      seenStart <= 1'b1;
    end
  end

  AST_PRESTART_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !seenStart |-> gateMask == '1);  // R1

  AST_DISABLED_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> gateMask == '1);  // R10

  AST_LOAD_ARMS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (loadEntry && entryCount > CNT_W'(1)) |=> !remainZero);  // R2

  AST_NO_LOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !loadEntry) |=> $stable(gateMask));  // R3

  AST_ZERO_NEVER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (entryCount == '0) |-> !loadEntry);  // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && enable && !cycleStart) |=> $stable(gateMask));  // R5

  AST_SWAP_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(activeBank) |-> ($past(pendingReady) && $past(cycleStart) && $past(enable)));  // R7

endmodule

bind gate_sched_seq gsq_checker #(
  .CNT_W (CNT_W),
  .MASK_W(MASK_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .cycleStart  (cycleStart),
  .gateMask    (gateMask),
  .loadEntry   (strobes.loadEntry),
  .holding     (ctrl_i.holding),
  .activeBank  (ctrl_i.activeBank),
  .pendingReady(ctrl_i.pendingReady),
  .entryCount  (entryCount),
  .remainZero  (remainZero)
);

// File: tb/gate_sched_seq_tb_top.sv
module gate_sched_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_TBL = 10;
  // Schedule 0: {3,01} {2,82} {1,44} {0,-}. Expected mask per clock after a start.
  localparam logic [7:0] EXP_TBL [N_TBL] = '{
    8'h01, 8'h01, 8'h01, 8'h82, 8'h82, 8'h44, 8'h44, 8'h44, 8'h44, 8'h44
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic        splitMode;
  logic        cycleStart;
  logic        wrEn;
  logic [6:0]  wrAddr;
  logic [21:0] wrData;
  logic        commit;
  logic [7:0]  gateMask;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gate_sched_seq dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .splitMode (splitMode),
    .cycleStart(cycleStart),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .commit    (commit),
    .gateMask  (gateMask)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: gateMask=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic writeEntry(input logic [6:0] addr, input logic [13:0] cnt, input logic [7:0] msk);
    wrEn   = 1'b1;
    wrAddr = addr;
    wrData = {cnt, msk};
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseStart();
    cycleStart = 1'b1;
    @(negedge clk);
    cycleStart = 1'b0;
  endtask

  task automatic pulseCommit();
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; splitMode = 1'b0; cycleStart = 1'b0;
    wrEn = 1'b0; wrAddr = '0; wrData = '0; commit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset value", gateMask, 8'hFF);

    // Program schedule 0 in single mode, then run it as bank 0 in split mode.
    writeEntry(7'd0, 14'd3, 8'h01);
    writeEntry(7'd1, 14'd2, 8'h82);
    writeEntry(7'd2, 14'd1, 8'h44);
    writeEntry(7'd3, 14'd0, 8'h00);
    splitMode = 1'b1;
    enable    = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 enabled before first start", gateMask, 8'hFF);

    // Vector walk: R2 durations, R3 ordering, R4 zero-count hold.
    pulseStart();
    for (int k = 0; k < N_TBL; k++) begin
      if (k > 0) @(negedge clk);
      check("R2 R3 R4 table", gateMask, EXP_TBL[k]);
    end

    // R6: restart in the middle of the second entry.
    pulseStart();
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      check("R6 restart run", gateMask, EXP_TBL[k]);
    end
    pulseStart();
    check("R6 restart mid-entry", gateMask, 8'h01);

    // R8: a write to the active bank 0 (wrAddr[6]=0) is dropped.
    writeEntry(7'd0, 14'd5, 8'hF0);
    pulseStart();
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      check("R8 active bank write dropped", gateMask, EXP_TBL[k]);
    end

    // R7: load bank 1, commit; the swap waits for a cycle start.
    writeEntry(7'd64, 14'd2, 8'h33);
    writeEntry(7'd65, 14'd0, 8'h00);
    pulseCommit();
    repeat (12) @(negedge clk);
    check("R7 no swap at commit", gateMask, 8'h44);
    pulseStart();
    check("R7 swapped at start k0", gateMask, 8'h33);
    @(negedge clk);
    check("R7 swapped at start k1", gateMask, 8'h33);
    @(negedge clk);
    check("R4 hold after bank1 list", gateMask, 8'h33);
    pulseStart();
    check("R7 same bank repeats", gateMask, 8'h33);

    // R11: bank 0 (now inactive, so writable per R8) starts with a zero count.
    writeEntry(7'd0, 14'd0, 8'hAA);
    pulseCommit();
    repeat (4) @(negedge clk);
    pulseStart();
    check("R11 zero first entry keeps mask", gateMask, 8'h33);
    repeat (3) @(negedge clk);
    check("R11 zero first entry still held", gateMask, 8'h33);

    // R5: fill all of bank 1 with one-clock entries; the last mask holds.
    for (int i = 0; i < 64; i++) writeEntry(7'(64 + i), 14'd1, 8'(i) ^ 8'h5A);
    pulseCommit();
    repeat (2) @(negedge clk);
    pulseStart();
    for (int k = 0; k < 64; k++) begin
      if (k > 0) @(negedge clk);
      check("R5 R3 full bank walk", gateMask, 8'(k) ^ 8'h5A);
    end
    repeat (6) @(negedge clk);
    check("R5 end of bank hold", gateMask, 8'h3F ^ 8'h5A);

    // R10: disable forces open; a start while disabled is ignored.
    enable = 1'b0;
    @(negedge clk);
    check("R10 disabled open", gateMask, 8'hFF);
    pulseStart();
    @(negedge clk);
    check("R10 start ignored while disabled", gateMask, 8'hFF);

    // R9: single 128-entry list runs across entry 63 into 64.
    splitMode = 1'b0;
    for (int i = 0; i < 128; i++) writeEntry(7'(i), 14'd1, 8'(i) ^ 8'hC3);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 re-enabled waits for start", gateMask, 8'hFF);
    pulseStart();
    for (int k = 0; k < 128; k++) begin
      if (k > 0) @(negedge clk);
      check("R9 single list walk", gateMask, 8'(k) ^ 8'hC3);
    end
    repeat (5) @(negedge clk);
    check("R9 R5 end of single list hold", gateMask, 8'h7F ^ 8'hC3);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule